// File: doc/BRIEF.md
# Bidirectional Parallel/Serial Bus Register

An eight-stage storage register placed between two 8-bit parallel ports, called A and B. Data can be loaded from either port and shown on the other. It can also be filled one bit at a time from a serial input. Each port is modelled as an input bus, an output bus and an output enable, so the register can share a system bus with others. The A side drives only while the bus-enable input is high.

Four control inputs select the operation:

- A mode select chooses between parallel and serial operation.
- A direction select chooses which port feeds the register.
- A timing select chooses whether a parallel load waits for the clock or follows the input port immediately.
- The A-side enable gates the A port; it is also how the register is told to hold its contents.

Loads that do not wait for the clock are built as a transparent path with an explicit strobe. The clock is never gated.

Top module: `bus_shift_reg`

## Requirements
- R1: While `rstN` is low, both `portAOe` and `portBOe` are low. A rising clock edge with `rstN` low clears all eight stages to 0.
- R2: With `parMode`=1, `dirAtoB`=1, `aEnable`=1 and `asyncLoad`=0, a rising edge stores `portAIn`. `portBOe` is 1 and `portAOe` is 0.
- R3: With `parMode`=1, `dirAtoB`=0 and `asyncLoad`=0, a rising edge stores `portBIn`. `portBOe` is 0. `portAOe` equals `aEnable`, and the load takes place whatever the value of `aEnable`.
- R4: With `parMode`=1, `asyncLoad`=1 and a load active (the conditions of R2 or R3), `portAOut` and `portBOut` follow the selected input port in the same cycle, without waiting for a clock edge. The stored value tracks that port at each edge, so after the mode is left the outputs show the value taken at the last edge.
- R5: With `parMode`=1, `dirAtoB`=1 and `aEnable`=0, the stored contents are held over clock edges whatever `portAIn` and `asyncLoad` carry, and `portBOe` is 1.
- R6: With `parMode`=0, each rising edge shifts the register:
  - bit 0 (stage 1) takes `serIn`;
  - bit k takes the old bit k-1;
  - the old bit 7 is discarded.
- R7: In serial mode `asyncLoad` has no effect. The outputs change only at rising edges, and shifting is the same for both values of `asyncLoad`.
- R8: Output enables follow the direction and A-side enable in every mode:
  - with `dirAtoB`=1, only `portBOe` is high;
  - with `dirAtoB`=0 and `aEnable`=1, only `portAOe` is high;
  - with `dirAtoB`=0 and `aEnable`=0, neither is high.
- R9: Outside the transparent case of R4, `portAOut` and `portBOut` both show the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| parMode | input | 1 | 1 selects parallel mode, 0 selects serial mode |
| dirAtoB | input | 1 | 1: A is the source and B the destination; 0: the reverse |
| asyncLoad | input | 1 | 1: parallel load without waiting for the clock (ignored in serial mode) |
| aEnable | input | 1 | Enables the A port; low together with `dirAtoB` high means hold |
| serIn | input | 1 | Serial data into stage 1 |
| portAIn | input | 8 | A port input data |
| portAOut | output | 8 | A port output data |
| portAOe | output | 1 | A port output enable |
| portBIn | input | 8 | B port input data |
| portBOut | output | 8 | B port output data |
| portBOe | output | 1 | B port output enable |

## Verification
The corner cases are these:

- The A-side enable going low while the direction is A-to-B. A design that got this wrong would keep loading from A instead of holding.
- The same enable going low while the direction is B-to-A. The load must still happen; a wrong design would block it along with the A drivers.
- The timing select set high in serial mode. A wrong design would let the outputs jump between clock edges or would stop shifting.
- Leaving the transparent load. A wrong design would fall back to stale contents rather than the value taken at the last edge.

Random mixes of modes and data are checked every half cycle against a bench model of the stored word. Directed sequences cover serial bit order and the drop of stage 8.

// File: rtl/bus_shift_reg_pkg.sv
package bus_shift_reg_pkg;
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic shift;
    logic transparent;
    logic driveA;
    logic driveB;
  } regStrobes_t;
endpackage

// File: rtl/bus_shift_reg_ctrl.sv
module bus_shift_reg_ctrl
  import bus_shift_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        parMode,
  input  logic        dirAtoB,
  input  logic        asyncLoad,
  input  logic        aEnable,
  output regStrobes_t strobes
);
  logic loadFromA, loadFromB;

  always_comb begin
    loadFromA = rstN && parMode && dirAtoB && aEnable;
    loadFromB = rstN && parMode && !dirAtoB;
    strobes.loadA       = loadFromA;
    strobes.loadB       = loadFromB;
    strobes.shift       = rstN && !parMode;
    strobes.transparent = asyncLoad && (loadFromA || loadFromB);
    strobes.driveA      = rstN && !dirAtoB && aEnable;
    strobes.driveB      = rstN && dirAtoB;
  end

  // R8: never both ports driving
  p_oe_exclusive_r8: assert property (@(posedge clk)
    $onehot0({strobes.driveA, strobes.driveB}));
  // R1: enables off under reset
  p_reset_oe_r1: assert property (@(posedge clk)
    !rstN |-> !(strobes.driveA || strobes.driveB));
  // R7: serial mode never opens the transparent path
  p_serial_sync_r7: assert property (@(posedge clk) disable iff (!rstN)
    !parMode |-> !strobes.transparent);
  // R5: hold request blocks every load
  p_hold_no_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (parMode && dirAtoB && !aEnable) |-> !(strobes.loadA || strobes.loadB || strobes.shift));
endmodule

// File: rtl/bus_shift_reg_datapath.sv
module bus_shift_reg_datapath
  import bus_shift_reg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobes_t      strobes,
  input  logic             serIn,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] view
);
  localparam int TopBit = WIDTH - 1;

  logic [WIDTH-1:0] stages;
  logic [WIDTH-1:0] loadSrc;
  logic             anyLoad;

  assign loadSrc = strobes.loadA ? aIn : bIn;
  assign anyLoad = strobes.loadA || strobes.loadB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stages <= '0;
    end else if (strobes.shift) begin
      stages <= {stages[TopBit-1:0], serIn};
    end else if (anyLoad) begin
      stages <= loadSrc;
    end
  end

  assign view = strobes.transparent ? loadSrc : stages;

  // R1: reset clears all stages
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> stages == '0);
  // R6: shift order, stage 8 dropped
  p_shift_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> stages == {$past(stages[TopBit-1:0]), $past(serIn)});
  // R2/R3: parallel capture at the edge
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    anyLoad |=> stages == $past(loadSrc));
  // R5: no strobe, no change
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(anyLoad || strobes.shift) |=> $stable(stages));
endmodule

// File: rtl/bus_shift_reg.sv
module bus_shift_reg
  import bus_shift_reg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             parMode,
  input  logic             dirAtoB,
  input  logic             asyncLoad,
  input  logic             aEnable,
  input  logic             serIn,
  input  logic [WIDTH-1:0] portAIn,
  output logic [WIDTH-1:0] portAOut,
  output logic             portAOe,
  input  logic [WIDTH-1:0] portBIn,
  output logic [WIDTH-1:0] portBOut,
  output logic             portBOe
);
  regStrobes_t      strobes;
  logic [WIDTH-1:0] view;

  bus_shift_reg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .parMode   (parMode),
    .dirAtoB   (dirAtoB),
    .asyncLoad (asyncLoad),
    .aEnable   (aEnable),
    .strobes   (strobes)
  );

  bus_shift_reg_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .serIn   (serIn),
    .aIn     (portAIn),
    .bIn     (portBIn),
    .view    (view)
  );

  assign portAOut = view;
  assign portBOut = view;
  assign portAOe  = strobes.driveA;
  assign portBOe  = strobes.driveB;
endmodule

// File: tb/bus_shift_reg_tb.sv
`timescale 1ns/1ps
module bus_shift_reg_tb;
  logic       clk = 1'b0;
  logic       rstN, parMode, dirAtoB, asyncLoad, aEnable, serIn;
  logic [7:0] portAIn, portBIn, portAOut, portBOut;
  logic       portAOe, portBOe;
  logic [7:0] model;
  int         nTests = 0;
  int         nFail  = 0;
  bit         done   = 1'b0;

  always #2.5 clk = ~clk;

  bus_shift_reg u_dut (
    .clk(clk), .rstN(rstN), .parMode(parMode), .dirAtoB(dirAtoB),
    .asyncLoad(asyncLoad), .aEnable(aEnable), .serIn(serIn),
    .portAIn(portAIn), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(portBIn), .portBOut(portBOut), .portBOe(portBOe)
  );

  function automatic bit loadingA();
    return rstN && parMode && dirAtoB && aEnable;
  endfunction
  function automatic bit loadingB();
    return rstN && parMode && !dirAtoB;
  endfunction
  function automatic bit isTransparent();
    return asyncLoad && (loadingA() || loadingB());
  endfunction
  function automatic logic [7:0] expView();
    if (isTransparent()) return loadingA() ? portAIn : portBIn;
    return model;
  endfunction
  function automatic string tagNow();
    if (!rstN) return "R1";
    if (!parMode) return asyncLoad ? "R7" : "R6";
    if (isTransparent()) return "R4";
    if (dirAtoB && !aEnable) return "R5";
    if (dirAtoB) return "R2";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: act aOe=%b bOe=%b a=%h b=%h exp aOe=%b bOe=%b a=%h b=%h",
               tag, act[17], act[16], act[15:8], act[7:0],
               exp[17], exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic checkAll(input string tag);
    logic eAOe, eBOe;
    eAOe = rstN && !dirAtoB && aEnable;  // R8
    eBOe = rstN && dirAtoB;              // R8
    check(tag, {portAOe, portBOe, portAOut, portBOut},
          {eAOe, eBOe, expView(), expView()});  // R9: both show view
  endtask

  // Clock edge: update model, then check after the edge
  task automatic edgeStep(input string tag);
    @(posedge clk);
    if (!rstN) model = 8'h00;
    else if (!parMode) model = {model[6:0], serIn};
    else if (loadingA()) model = portAIn;
    else if (loadingB()) model = portBIn;
    #0.5;
    checkAll(tag);
  endtask

  task automatic setCtl(input bit r, input bit p, input bit d, input bit s, input bit e);
    @(negedge clk);
    rstN = r; parMode = p; dirAtoB = d; asyncLoad = s; aEnable = e;
  endtask

  initial begin
    #200000;
    nTests++; nFail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [7:0] pattern;
    void'($urandom(32'd1234));
    model = 8'h5A;
    rstN = 0; parMode = 1; dirAtoB = 1; asyncLoad = 0; aEnable = 1;
    serIn = 0; portAIn = 8'hFF; portBIn = 8'hEE;
    #1;
    check("R1", {portAOe, portBOe, 16'h0}, 18'h0);  // enables off in reset
    edgeStep("R1");
    edgeStep("R1");

    // R2: sync A to B load
    setCtl(1, 1, 1, 0, 1); portAIn = 8'h3C;
    #0.5; checkAll("R2");
    edgeStep("R2");
    // R5: hold with A changing, both timing modes
    setCtl(1, 1, 1, 0, 0); portAIn = 8'hC3;
    edgeStep("R5");
    setCtl(1, 1, 1, 1, 0); portAIn = 8'h99;
    #0.5; checkAll("R5");
    edgeStep("R5");
    // R3: B to A with aEnable low still loads
    setCtl(1, 1, 0, 0, 0); portBIn = 8'hA7;
    edgeStep("R3");
    setCtl(1, 1, 0, 0, 1);
    #0.5; checkAll("R8");
    // R4: transparent follow, then leave
    setCtl(1, 1, 1, 1, 1); portAIn = 8'h11;
    #0.5; checkAll("R4");
    #0.5; portAIn = 8'h22; #0.2; checkAll("R4");
    edgeStep("R4");
    setCtl(1, 1, 1, 0, 0); portAIn = 8'h77;
    #0.5; checkAll("R4");
    // R6: serial shift of a known pattern, old bits dropped
    pattern = 8'b1011_0010;
    for (int i = 7; i >= 0; i--) begin
      setCtl(1, 0, 1, 0, 1); serIn = pattern[i];
      edgeStep("R6");
    end
    check("R6", {2'b0, 8'h0, portBOut}, {2'b0, 8'h0, pattern});
    // R7: serial with asyncLoad high, B input ignored
    setCtl(1, 0, 0, 1, 1); serIn = 1; portBIn = 8'h00;
    #0.5; checkAll("R7");
    edgeStep("R7");
    setCtl(1, 0, 0, 1, 0);
    #0.5; checkAll("R8");

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      rstN      = ($urandom_range(0, 19) != 0);
      parMode   = $urandom_range(0, 1);
      dirAtoB   = $urandom_range(0, 1);
      asyncLoad = $urandom_range(0, 1);
      aEnable   = $urandom_range(0, 1);
      serIn     = $urandom_range(0, 1);
      portAIn   = 8'($urandom);
      portBIn   = 8'($urandom);
      #0.5; checkAll(tagNow());
      edgeStep(tagNow());
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule